// File: doc/BRIEF.md
# Manchester II Frame Receiver with Sync Classification

This block receives serial frames in Manchester II (biphase-level) form. It takes either a complementary pair of line inputs or a single-ended input, and a control input picks between them. It samples the line with a clock running twelve times the bit rate. It searches the line for a three-bit-period sync pattern. The pattern holds one level for one and a half bit periods and then the opposite level for one and a half bit periods. The block reports which way round the pattern was: a high-first sync is a command sync and a low-first sync is a data sync.

Once a sync is locked, the block recovers a programmed number of data bits, from 2 to 28. It presents each bit on a serial output with a one-clock strobe, and it raises a window signal around the data bits. It then reads the trailing parity bit and checks it against a selectable even or odd sense. If every bit had a mid-bit transition and the parity agreed, a word-valid output is raised for one bit period, after which the receiver goes back to searching. A synchronous receiver-only reset sits beside the asynchronous master reset.

Top module: `manch_rx`

## Requirements
- R1: A sync is accepted only if the line holds one level for 15 to 21 sample clocks (nominally 18, i.e. 1.5 bit periods) and then holds the opposite level for at least the next 15 sample clocks. Any other run pattern, for example a 12-sample or 26-sample first half, leaves the receiver searching, and `take_data` stays low.
- R2: `cmd_sync` is set to 1 when the accepted sync was high first (command sync) and to 0 when it was low first (data sync). It holds that value until the next accepted sync and is cleared by either reset.
- R3: The data word length is taken from the 5-bit `len_code`. A value from 2 to 28 gives that many bits, values 0 and 1 give 2 bits, and values 29 to 31 give 28 bits. Exactly that many `shift_clk` strobes occur per frame.
- R4: Each data bit is 1 when its first half is high and its second half low, and 0 for the reverse. Bits appear on `data_out` in order of arrival, and `data_out` is valid in every cycle in which `shift_clk` is high.
- R5: `take_data` is high only during the data bits of a frame (12·N−1 sample clocks for N bits). `shift_clk` is a single-cycle pulse that only occurs while `take_data` is high.
- R6: One parity bit follows the data. With `odd_parity`=1, the data ones plus the parity bit must be odd; with 0 they must be even. A mismatch suppresses `valid_word`.
- R7: A data bit or parity bit with no mid-bit transition is a Manchester error and suppresses `valid_word` for that frame. The data strobes still occur.
- R8: On a correct frame, `valid_word` goes high right after the parity bit, stays high for exactly 12 sample clocks (one bit period) and is never high together with `take_data`. The receiver then searches for the next sync and decodes the next frame.
- R9: With `sel_unipolar`=1 the line is `uni_in`, and the pair inputs have no effect. With `sel_unipolar`=0 the line is high when `bip_one_in`=1 and `bip_zero_in`=0, and `uni_in` has no effect.
- R10: `dec_rst` high at a clock edge drives `take_data`, `valid_word`, `shift_clk` and `cmd_sync` low from that edge on and restarts the sync search. `rst_n` low clears them at once without a clock.
- R11: After master reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 12 times the bit rate |
| rst_n | input | 1 | Asynchronous master reset, active low |
| dec_rst | input | 1 | Synchronous receiver reset, active high |
| sel_unipolar | input | 1 | 1: use `uni_in`; 0: use the complementary pair |
| bip_one_in | input | 1 | Pair input, high for a line one |
| bip_zero_in | input | 1 | Pair input, high for a line zero |
| uni_in | input | 1 | Single-ended line input |
| len_code | input | 5 | Data word length code (clamped to 2..28) |
| odd_parity | input | 1 | Parity sense: 1 odd, 0 even |
| cmd_sync | output | 1 | Type of the last accepted sync: 1 command, 0 data |
| data_out | output | 1 | Recovered serial data bit |
| shift_clk | output | 1 | One-cycle strobe per recovered data bit |
| take_data | output | 1 | High across the data-bit window |
| valid_word | output | 1 | One-bit-period pulse after a correct frame |

## Verification
The bench feeds frames whose sync first half is 12 or 26 samples long. A receiver with a window that is too wide would lock on these and open a data window. It drives the extreme length codes 0, 1 and 31, where a missing clamp would yield too few or too many strobes. It sends frames with an inverted parity bit and frames with a bit that lacks its mid-bit transition; a design that skips either check would still pulse `valid_word`. It drives the unused inputs with the inverted line so that a wrong input selection corrupts the data. It also pulses the receiver reset in the middle of a long word and then checks that the next frame is still decoded. A reset that did not reach the bit engine or the sync detector would leave stale output or a dead receiver.

// File: rtl/manch_rx_pkg.sv
package manch_rx_pkg;

  typedef enum logic {SD_HUNT, SD_TAIL} sd_state_t;

  typedef enum logic [1:0] {BE_IDLE, BE_BITS, BE_GOOD} be_state_t;

  // Clamp the programmed length code into the supported word range.
  function automatic logic [4:0] word_len(input logic [4:0] code);
    if (code < 5'd2)       return 5'd2;
    else if (code > 5'd28) return 5'd28;
    else                   return code;
  endfunction

  // acc is the XOR of all data bits and the parity bit.
  function automatic logic parity_good(input logic acc, input logic odd_sense);
    return acc == odd_sense;
  endfunction

endpackage

// File: rtl/manch_rx_line.sv
module manch_rx_line (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_unipolar,
  input  logic uni_in,
  input  logic bip_one_in,
  input  logic bip_zero_in,
  output logic line
);

  logic line_next;

  always_comb begin
    if (sel_unipolar) line_next = uni_in;
    else              line_next = bip_one_in & ~bip_zero_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line <= 1'b0;
    else        line <= line_next;
  end

endmodule

// File: rtl/manch_rx_sync.sv
module manch_rx_sync
  import manch_rx_pkg::*;
#(
  parameter int SYNC_LEN = 18,
  parameter int SYNC_TOL = 3,
  parameter int CW       = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst,
  input  logic en,
  input  logic line,
  output logic sync_hit,
  output logic sync_cmd
);

  localparam int SYNC_MIN = SYNC_LEN - SYNC_TOL;
  localparam int SYNC_MAX = SYNC_LEN + SYNC_TOL;

  sd_state_t     st;
  logic          prev;
  logic          first_lvl;
  logic [CW-1:0] run;
  logic          run_in_win;

  assign run_in_win = (run >= CW'(SYNC_MIN)) && (run <= CW'(SYNC_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SD_HUNT;
      prev      <= 1'b0;
      first_lvl <= 1'b0;
      run       <= '0;
      sync_hit  <= 1'b0;
      sync_cmd  <= 1'b0;
    end else if (srst || !en) begin
      st       <= SD_HUNT;
      prev     <= line;
      run      <= '0;
      sync_hit <= 1'b0;
      if (srst) sync_cmd <= 1'b0;
    end else begin
      sync_hit <= 1'b0;
      prev     <= line;
      case (st)
        SD_HUNT: begin
          if (line == prev) begin
            if (run != '1) run <= run + 1'b1;
          end else begin
            if (run_in_win) begin
              st        <= SD_TAIL;
              first_lvl <= prev;
            end
            run <= CW'(1);
          end
        end
        SD_TAIL: begin
          // run = index of the last second-half sample already seen
          if (line == first_lvl && run < CW'(SYNC_MIN)) begin
            st  <= SD_HUNT;
            run <= CW'(1);
          end else if (run == CW'(SYNC_LEN - 1)) begin
            sync_hit <= 1'b1;
            sync_cmd <= first_lvl;
            st       <= SD_HUNT;
            run      <= '0;
          end else begin
            run <= run + 1'b1;
          end
        end
        default: st <= SD_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/manch_rx_bits.sv
module manch_rx_bits
  import manch_rx_pkg::*;
#(
  parameter int SPB = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       srst,
  input  logic       sync_hit,
  input  logic       line,
  input  logic [4:0] len_code,
  input  logic       odd_parity,
  output logic       busy,
  output logic       take_data,
  output logic       shift_clk,
  output logic       data_out,
  output logic       valid_word,
  output logic       frame_done,
  output logic       frame_ok
);

  localparam int HALF = SPB / 2;
  localparam int Q1   = HALF / 2;
  localparam int Q3   = HALF + Q1;
  localparam int PW   = $clog2(SPB);

  be_state_t     st;
  logic [PW-1:0] pos;
  logic [4:0]    bit_idx;
  logic [4:0]    nb;
  logic          odd_q;
  logic          h1;
  logic          acc;
  logic          err;
  logic          last_pos;

  assign last_pos   = (pos == PW'(SPB - 1));
  assign busy       = (st != BE_IDLE);
  assign take_data  = (st == BE_BITS) && (bit_idx < nb);
  assign valid_word = (st == BE_GOOD);
  assign frame_done = (st == BE_BITS) && last_pos && (bit_idx == nb);
  assign frame_ok   = !err && parity_good(acc, odd_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= BE_IDLE;
      pos       <= '0;
      bit_idx   <= '0;
      nb        <= 5'd2;
      odd_q     <= 1'b0;
      h1        <= 1'b0;
      acc       <= 1'b0;
      err       <= 1'b0;
      shift_clk <= 1'b0;
      data_out  <= 1'b0;
    end else if (srst) begin
      st        <= BE_IDLE;
      pos       <= '0;
      bit_idx   <= '0;
      shift_clk <= 1'b0;
      data_out  <= 1'b0;
    end else begin
      shift_clk <= 1'b0;
      case (st)
        BE_IDLE: begin
          if (sync_hit) begin
            st      <= BE_BITS;
            pos     <= PW'(1);
            bit_idx <= '0;
            err     <= 1'b0;
            acc     <= 1'b0;
            nb      <= word_len(len_code);
            odd_q   <= odd_parity;
          end
        end
        BE_BITS: begin
          if (pos == PW'(Q1)) h1 <= line;
          if (pos == PW'(Q3)) begin
            acc <= acc ^ h1;
            if (h1 == line) err <= 1'b1;
            if (bit_idx < nb) begin
              data_out  <= h1;
              shift_clk <= 1'b1;
            end
          end
          if (last_pos) begin
            pos <= '0;
            if (bit_idx == nb) st <= frame_ok ? BE_GOOD : BE_IDLE;
            else               bit_idx <= bit_idx + 1'b1;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        BE_GOOD: begin
          if (last_pos) begin
            st  <= BE_IDLE;
            pos <= '0;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        default: st <= BE_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/manch_rx.sv
module manch_rx
  import manch_rx_pkg::*;
#(
  parameter int SPB      = 12,
  parameter int SYNC_TOL = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dec_rst,
  input  logic       sel_unipolar,
  input  logic       bip_one_in,
  input  logic       bip_zero_in,
  input  logic       uni_in,
  input  logic [4:0] len_code,
  input  logic       odd_parity,
  output logic       cmd_sync,
  output logic       data_out,
  output logic       shift_clk,
  output logic       take_data,
  output logic       valid_word
);

  localparam int SYNC_LEN = 3 * (SPB / 2);
  localparam int CW       = $clog2(SYNC_LEN + SYNC_TOL + 2);

  logic line;
  logic sync_hit;
  logic busy;
  logic frame_done;
  logic frame_ok;

  manch_rx_line u_line (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_unipolar (sel_unipolar),
    .uni_in       (uni_in),
    .bip_one_in   (bip_one_in),
    .bip_zero_in  (bip_zero_in),
    .line         (line)
  );

  manch_rx_sync #(
    .SYNC_LEN (SYNC_LEN),
    .SYNC_TOL (SYNC_TOL),
    .CW       (CW)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .srst     (dec_rst),
    .en       (!busy),
    .line     (line),
    .sync_hit (sync_hit),
    .sync_cmd (cmd_sync)
  );

  manch_rx_bits #(
    .SPB (SPB)
  ) u_bits (
    .clk        (clk),
    .rst_n      (rst_n),
    .srst       (dec_rst),
    .sync_hit   (sync_hit),
    .line       (line),
    .len_code   (len_code),
    .odd_parity (odd_parity),
    .busy       (busy),
    .take_data  (take_data),
    .shift_clk  (shift_clk),
    .data_out   (data_out),
    .valid_word (valid_word),
    .frame_done (frame_done),
    .frame_ok   (frame_ok)
  );

endmodule

// File: rtl/manch_rx_chk.sv
module manch_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic dec_rst,
  input logic sync_hit,
  input logic frame_done,
  input logic frame_ok,
  input logic shift_clk,
  input logic take_data,
  input logic valid_word,
  input logic cmd_sync
);

  // R8
  valid_take_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_word && take_data));

  // R5
  shift_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_clk |-> take_data);

  // R5
  shift_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_clk |=> !shift_clk);

  // R10
  dec_rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_rst |=> (!take_data && !valid_word && !shift_clk && !cmd_sync));

  // R6
  valid_after_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_word) |-> $past(frame_done && frame_ok));

  // R1
  window_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_data) |-> $past(sync_hit));

endmodule

bind manch_rx manch_rx_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .dec_rst    (dec_rst),
  .sync_hit   (sync_hit),
  .frame_done (frame_done),
  .frame_ok   (frame_ok),
  .shift_clk  (shift_clk),
  .take_data  (take_data),
  .valid_word (valid_word),
  .cmd_sync   (cmd_sync)
);

// File: tb/manch_rx_tb_top.sv
module manch_rx_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_rst = 1'b0;
  logic       sel_unipolar = 1'b0;
  logic       bip_one_in = 1'b0;
  logic       bip_zero_in = 1'b1;
  logic       uni_in = 1'b0;
  logic [4:0] len_code = 5'd2;
  logic       odd_parity = 1'b0;
  logic       cmd_sync, data_out, shift_clk, take_data, valid_word;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // running tallies, updated only at falling edges
  int         n_shift = 0, n_valid = 0, n_take = 0;
  logic [27:0] cap = '0;

  // {uni, cmd, odd, code[4:0], flip_parity, data[27:0]}
  localparam logic [36:0] VEC [0:7] = '{
    {1'b0, 1'b1, 1'b1, 5'd16, 1'b0, 28'h000A5C3},
    {1'b1, 1'b0, 1'b0, 5'd5,  1'b0, 28'h0000015},
    {1'b0, 1'b0, 1'b1, 5'd0,  1'b0, 28'h0000002},
    {1'b1, 1'b1, 1'b0, 5'd31, 1'b0, 28'hABCDEF1},
    {1'b0, 1'b1, 1'b0, 5'd8,  1'b1, 28'h000003C},
    {1'b1, 1'b1, 1'b1, 5'd28, 1'b0, 28'h0000000},
    {1'b0, 1'b0, 1'b0, 5'd12, 1'b1, 28'h0000FFF},
    {1'b1, 1'b0, 1'b1, 5'd1,  1'b0, 28'h0000001}
  };

  manch_rx dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .dec_rst      (dec_rst),
    .sel_unipolar (sel_unipolar),
    .bip_one_in   (bip_one_in),
    .bip_zero_in  (bip_zero_in),
    .uni_in       (uni_in),
    .len_code     (len_code),
    .odd_parity   (odd_parity),
    .cmd_sync     (cmd_sync),
    .data_out     (data_out),
    .shift_clk    (shift_clk),
    .take_data    (take_data),
    .valid_word   (valid_word)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (shift_clk) begin
      cap     <= {cap[26:0], data_out};
      n_shift <= n_shift + 1;
    end
    if (valid_word) n_valid <= n_valid + 1;
    if (take_data)  n_take  <= n_take + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad   = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, act=%0d expected<=150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // drive a line level for n sample clocks; unused inputs get the inverse (R9)
  task automatic put(input logic lvl, input int n);
    if (sel_unipolar) begin
      uni_in = lvl; bip_one_in = ~lvl; bip_zero_in = lvl;
    end else begin
      bip_one_in = lvl; bip_zero_in = ~lvl; uni_in = ~lvl;
    end
    repeat (n) @(negedge clk);
  endtask

  function automatic int clamp_len(input logic [4:0] code);
    int v = int'(code);
    if (v < 2)  v = 2;
    if (v > 28) v = 28;
    return v;
  endfunction

  task automatic tx_frame(input logic uni, input logic cmd, input logic odd,
                          input logic [4:0] code, input logic flip,
                          input logic [27:0] data, input int errbit);
    int   n = clamp_len(code);
    int   ones = 0;
    logic p;
    sel_unipolar = uni;
    odd_parity   = odd;
    len_code     = code;
    put(~cmd, 30);
    put(cmd, 18);
    put(~cmd, 18);
    for (int i = n - 1; i >= 0; i--) begin
      if (data[i]) ones++;
      if (i == errbit) put(data[i], 12);
      else begin put(data[i], 6); put(~data[i], 6); end
    end
    p = odd ? ~ones[0] : ones[0];
    p = p ^ flip;
    put(p, 6);
    put(~p, 6);
    put(~cmd, 40);
  endtask

  int s_shift, s_valid, s_take;
  task automatic snap();
    @(posedge clk);
    s_shift = n_shift; s_valid = n_valid; s_take = n_take;
    @(negedge clk);
  endtask

  task automatic frame_chk(input logic uni, input logic cmd, input logic odd,
                           input logic [4:0] code, input logic flip,
                           input logic [27:0] data, input int errbit);
    int          n = clamp_len(code);
    logic [27:0] mask = (n == 28) ? 28'hFFFFFFF : ((28'd1 << n) - 28'd1);
    int          exp_valid = (flip || errbit >= 0) ? 0 : 12;
    snap();
    tx_frame(uni, cmd, odd, code, flip, data, errbit);
    @(posedge clk);
    check(n_shift - s_shift == n, "R3 strobe count", n_shift - s_shift, n);
    check((cap & mask) == (data & mask), "R4/R9 recovered bits",
          int'(cap & mask), int'(data & mask));
    check(cmd_sync == cmd, "R2 sync type", int'(cmd_sync), int'(cmd));
    check(n_take - s_take == 12 * n - 1, "R5 window length", n_take - s_take, 12 * n - 1);
    if (errbit >= 0)
      check(n_valid - s_valid == exp_valid, "R7 manchester error", n_valid - s_valid, exp_valid);
    else if (flip)
      check(n_valid - s_valid == exp_valid, "R6 parity", n_valid - s_valid, exp_valid);
    else
      check(n_valid - s_valid == exp_valid, "R8 valid width", n_valid - s_valid, exp_valid);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(cmd_sync == 0 && data_out == 0, "R11 reset cmd/data", int'({cmd_sync, data_out}), 0);
    check(shift_clk == 0 && take_data == 0 && valid_word == 0, "R11 reset strobes",
          int'({shift_clk, take_data, valid_word}), 0);
    rst_n = 1'b1;
    put(1'b0, 20);

    // table of frames: R2 R3 R4 R5 R6 R8 R9
    for (int k = 0; k < 8; k++)
      frame_chk(VEC[k][36], VEC[k][35], VEC[k][34], VEC[k][33:29],
                VEC[k][28], VEC[k][27:0], -1);

    // R7 missing mid-bit transition
    frame_chk(1'b0, 1'b1, 1'b0, 5'd10, 1'b0, 28'h2D5, 4);

    // R1 sync first half too short
    snap();
    sel_unipolar = 1'b0;
    put(1'b0, 30); put(1'b1, 12); put(1'b0, 18);
    for (int i = 0; i < 6; i++) begin put(1'b1, 6); put(1'b0, 6); end
    put(1'b0, 40);
    @(posedge clk);
    check(n_take == s_take, "R1 short sync ignored", n_take - s_take, 0);
    @(negedge clk);

    // R1 sync first half too long
    snap();
    put(1'b1, 26); put(1'b0, 18);
    for (int i = 0; i < 6; i++) begin put(1'b0, 6); put(1'b1, 6); end
    put(1'b0, 40);
    @(posedge clk);
    check(n_take == s_take, "R1 long sync ignored", n_take - s_take, 0);
    @(negedge clk);

    // R10 receiver reset in the middle of a word
    snap();
    fork
      tx_frame(1'b1, 1'b1, 1'b1, 5'd28, 1'b0, 28'h5A5A5A5, -1);
      begin
        repeat (150) @(negedge clk);
        dec_rst = 1'b1;
        @(negedge clk);
        dec_rst = 1'b0;
        check(take_data == 0 && valid_word == 0 && cmd_sync == 0, "R10 dec_rst clear",
              int'({take_data, valid_word, cmd_sync}), 0);
      end
    join
    @(posedge clk);
    check(n_valid == s_valid, "R10 aborted frame not valid", n_valid - s_valid, 0);
    @(negedge clk);

    // R8 receiver recovers and decodes the next frame
    frame_chk(1'b0, 1'b0, 1'b1, 5'd6, 1'b0, 28'h2B, -1);

    // R10 asynchronous master reset mid-frame
    fork
      tx_frame(1'b0, 1'b1, 1'b0, 5'd20, 1'b0, 28'h0F0F0, -1);
      begin
        repeat (120) @(negedge clk);
        #2 rst_n = 1'b0;
        #1 check(take_data == 0 && cmd_sync == 0 && shift_clk == 0, "R10 async reset",
                 int'({take_data, cmd_sync, shift_clk}), 0);
        @(negedge clk);
        rst_n = 1'b1;
      end
    join
    put(1'b0, 20);
    frame_chk(1'b1, 1'b1, 1'b0, 5'd3, 1'b0, 28'h5, -1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule